// File: doc/BRIEF.md
# SPI FIFO Status and Request Unit

This unit sits between the bus side and the shift engine of a SPI controller. It holds a transmit queue filled by bus writes and drained by the engine, and a receive queue filled by the engine and drained by bus reads. Each queue is four entries deep by default and reports its fill count and the index of the entry it will hand out next.

Seven sticky status flags record queue conditions and engine events. Software clears a flag by writing one to it. Six of the flags can raise a request when their enable bit is set. The receive-drain and transmit-fill requests can each be sent either to the shared interrupt line or to their own DMA request line. Control inputs empty either queue, shrink either queue to one entry, and choose whether a receive frame that arrives at a full queue is dropped or replaces the oldest entry.

Top module: `spi_fifo_stat_unit`

## Requirements
- R1: While reset is held, every flag, both counts, both next pointers, `irq` and both DMA lines are 0. The transmit-fill flag (bit 2) rises on the first clock edge after reset is released, because the transmit queue is empty.
- R2: Each queue returns words in the order they were written and holds at most DEPTH (4) entries. `tx_count` and `rx_count` give the entry count. `tx_ptr` and `rx_ptr` give the index of the next entry to leave, counting modulo DEPTH. A transmit push into a full queue is dropped and leaves the count unchanged.
- R3: A receive frame that arrives at a full queue with no read in the same cycle sets the overflow flag (bit 1). With `rx_overwrite` = 0 the frame is dropped. With `rx_overwrite` = 1 it replaces the oldest entry, the count stays the same, and the next pointer advances by one.
- R4: When the engine requests a transmit word and the transmit queue is empty, `eng_tx_valid` is 0 and the underflow flag (bit 3) is set on that clock edge.
- R5: `tx_flush` or `rx_flush` sets that queue's count and next pointer to 0 on the next edge. A push in the same cycle as a flush is discarded.
- R6: When `tx_fifo_off` or `rx_fifo_off` is 1, that queue holds at most one entry. Drop-or-overwrite on the receive side still follows R3.
- R7: Writing 1 to a bit of `flag_clr` clears that flag on the next edge. Bits written as 0 leave their flags alone. If a flag's set condition is true in the same cycle as its clear, the flag stays set.
- R8: The receive-drain flag (bit 0) is set again on every edge while the receive queue is not empty. The transmit-fill flag (bit 2) is set again on every edge while the transmit queue has a free entry. Either flag can be cleared only after its condition has gone away.
- R9: A flag with bits 0 to 5 raises a request only when the matching `req_en` bit is 1. `req_en` uses the same bit numbering as the flags.
- R10: `rx_drain_dma` = 1 routes the receive-drain request to `rx_dma_req` and not to `irq`. `tx_fill_dma` = 1 does the same for the transmit-fill request and `tx_dma_req`. When the select is 0, the request goes to `irq`.
- R11: `eng_eoq` sets the end-of-queue flag (bit 4). `eng_done` sets the transfer-complete flag (bit 5). The running flag (bit 6) is set on every edge while `eng_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_fifo_off | input | 1 | Transmit queue limited to one entry |
| rx_fifo_off | input | 1 | Receive queue limited to one entry |
| rx_overwrite | input | 1 | Receive frame at a full queue replaces the oldest entry |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| tx_push | input | 1 | Bus writes a transmit word |
| tx_push_data | input | TXW | Transmit word |
| eng_tx_req | input | 1 | Engine takes the next transmit word |
| eng_tx_valid | output | 1 | Transmit word available |
| eng_tx_data | output | TXW | Next transmit word |
| eng_rx_valid | input | 1 | Engine delivers a received frame |
| eng_rx_data | input | RXW | Received frame |
| rx_pop | input | 1 | Bus reads a receive word |
| rx_pop_data | output | RXW | Oldest receive word |
| eng_eoq | input | 1 | End-of-queue event from the engine |
| eng_done | input | 1 | Transfer-complete event from the engine |
| eng_busy | input | 1 | Engine is running |
| flag_clr | input | 7 | Write-one-to-clear strobe for each flag |
| flags | output | 7 | Status flags |
| req_en | input | 6 | Request enable for each of flags 0 to 5 |
| rx_drain_dma | input | 1 | Route the drain request to DMA |
| tx_fill_dma | input | 1 | Route the fill request to DMA |
| irq | output | 1 | Interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_count | output | STW | Transmit entry count |
| tx_ptr | output | STW | Transmit next pointer |
| rx_count | output | STW | Receive entry count |
| rx_ptr | output | STW | Receive next pointer |

## Verification
The bench creates two same-cycle conflicts. In the first, a write-one clear lands in the same cycle as the event or level that sets the flag. This is done with an end-of-queue pulse, a held busy level, and a non-empty receive queue, and in each case the flag must read 1 afterwards. In the second, a flush lands in the same cycle as a push. The bench then checks that the count and pointer read 0, and that the next word written is the first word read out, with no trace of the dropped push.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
   localparam int NFLAG   = 7;
   localparam int NREQ    = 6;
   localparam int F_RXDRN = 0;
   localparam int F_RXOVF = 1;
   localparam int F_TXFIL = 2;
   localparam int F_TXUNF = 3;
   localparam int F_EOQ   = 4;
   localparam int F_TC    = 5;
   localparam int F_RUN   = 6;
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   parameter int STW   = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           single,
   input  logic           flush,
   input  logic           ovr_en,
   input  logic           push,
   input  logic [W-1:0]   pdata,
   input  logic           pop,
   output logic [W-1:0]   rdata,
   output logic           empty,
   output logic           full,
   output logic [STW-1:0] count,
   output logic [STW-1:0] ptr
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfq_fifo: DEPTH must be a power of two of at least 2");
   end
   if (DEPTH >= (1 << STW)) begin : g_bad_stw
      $error("sfq_fifo: STW too narrow for DEPTH");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cap;
   logic          do_pop, do_push, do_ovw;

   assign cap     = single ? CW'(1) : CW'(DEPTH);
   assign full    = cnt_q >= cap;
   assign empty   = cnt_q == '0;
   assign do_pop  = pop & ~empty;
   assign do_ovw  = push & full & ~do_pop & ovr_en;
   assign do_push = push & (~full | do_pop | ovr_en);

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_q] <= pdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + PW'(1);
         if (do_pop || do_ovw) rd_q <= rd_q + PW'(1);
         if (do_push && !do_pop && !do_ovw) cnt_q <= cnt_q + CW'(1);
         else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
      end
   end

   assign rdata = mem[rd_q];
   assign count = STW'(cnt_q);
   assign ptr   = STW'(rd_q);

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   p_flush_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0 && rd_q == '0));
   p_overwrite_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && ovr_en && !flush) |=> $stable(cnt_q));
   p_single_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (single && cnt_q == CW'(1) && push && !pop && !ovr_en && !flush) |=> cnt_q == CW'(1));
endmodule

// File: rtl/sfq_req.sv
module sfq_req
   import sfq_pkg::*;
(
   input  logic [NREQ-1:0] flag,
   input  logic [NREQ-1:0] en,
   input  logic            rx_sel_dma,
   input  logic            tx_sel_dma,
   output logic            irq,
   output logic            rx_dma,
   output logic            tx_dma
);
   logic [NREQ-1:0] irq_v, dma_v;

   for (genvar k = 0; k < NREQ; k++) begin : g_src
      if (k == F_RXDRN || k == F_TXFIL) begin : g_steer
         logic sel;
         assign sel      = (k == F_RXDRN) ? rx_sel_dma : tx_sel_dma;
         assign irq_v[k] = flag[k] & en[k] & ~sel;
         assign dma_v[k] = flag[k] & en[k] & sel;
      end else begin : g_plain
         assign irq_v[k] = flag[k] & en[k];
         assign dma_v[k] = 1'b0;
      end
   end

   assign irq    = |irq_v;
   assign rx_dma = dma_v[F_RXDRN];
   assign tx_dma = dma_v[F_TXFIL];

   logic unused_dma;
   assign unused_dma = ^dma_v;
endmodule

// File: rtl/spi_fifo_stat_unit.sv
module spi_fifo_stat_unit
   import sfq_pkg::*;
#(
   parameter int TXW   = 16,
   parameter int RXW   = 32,
   parameter int DEPTH = 4,
   parameter int STW   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_fifo_off,
   input  logic             rx_fifo_off,
   input  logic             rx_overwrite,
   input  logic             tx_flush,
   input  logic             rx_flush,
   input  logic             tx_push,
   input  logic [TXW-1:0]   tx_push_data,
   input  logic             eng_tx_req,
   output logic             eng_tx_valid,
   output logic [TXW-1:0]   eng_tx_data,
   input  logic             eng_rx_valid,
   input  logic [RXW-1:0]   eng_rx_data,
   input  logic             rx_pop,
   output logic [RXW-1:0]   rx_pop_data,
   input  logic             eng_eoq,
   input  logic             eng_done,
   input  logic             eng_busy,
   input  logic [NFLAG-1:0] flag_clr,
   output logic [NFLAG-1:0] flags,
   input  logic [NREQ-1:0]  req_en,
   input  logic             rx_drain_dma,
   input  logic             tx_fill_dma,
   output logic             irq,
   output logic             rx_dma_req,
   output logic             tx_dma_req,
   output logic [STW-1:0]   tx_count,
   output logic [STW-1:0]   tx_ptr,
   output logic [STW-1:0]   rx_count,
   output logic [STW-1:0]   rx_ptr
);
   logic tx_empty, tx_full, rx_empty, rx_full;
   logic [NFLAG-1:0] flag_q, flag_set;

   sfq_fifo #(.W(TXW), .DEPTH(DEPTH), .STW(STW)) u_txq (
      .clk(clk), .rst_n(rst_n), .single(tx_fifo_off), .flush(tx_flush),
      .ovr_en(1'b0), .push(tx_push), .pdata(tx_push_data), .pop(eng_tx_req),
      .rdata(eng_tx_data), .empty(tx_empty), .full(tx_full),
      .count(tx_count), .ptr(tx_ptr));

   sfq_fifo #(.W(RXW), .DEPTH(DEPTH), .STW(STW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .single(rx_fifo_off), .flush(rx_flush),
      .ovr_en(rx_overwrite), .push(eng_rx_valid), .pdata(eng_rx_data), .pop(rx_pop),
      .rdata(rx_pop_data), .empty(rx_empty), .full(rx_full),
      .count(rx_count), .ptr(rx_ptr));

   assign eng_tx_valid = ~tx_empty;

   always_comb begin
      flag_set          = '0;
      flag_set[F_RXDRN] = ~rx_empty;
      flag_set[F_RXOVF] = eng_rx_valid & rx_full & ~rx_pop;
      flag_set[F_TXFIL] = ~tx_full;
      flag_set[F_TXUNF] = eng_tx_req & tx_empty;
      flag_set[F_EOQ]   = eng_eoq;
      flag_set[F_TC]    = eng_done;
      flag_set[F_RUN]   = eng_busy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~flag_clr) | flag_set;
   end

   assign flags = flag_q;

   sfq_req u_req (
      .flag(flag_q[NREQ-1:0]), .en(req_en), .rx_sel_dma(rx_drain_dma),
      .tx_sel_dma(tx_fill_dma), .irq(irq), .rx_dma(rx_dma_req), .tx_dma(tx_dma_req));

   p_underflow_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_tx_req && tx_count == '0) |=> flags[F_TXUNF]);
   p_overflow_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_valid && rx_full && !rx_pop) |=> flags[F_RXOVF]);
   p_clear_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[F_EOQ] && !eng_eoq) |=> !flags[F_EOQ]);
   p_dma_quiet_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en == 6'b000101 && rx_drain_dma && tx_fill_dma) |-> !irq);
   p_no_enable_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_en == '0) |-> (!irq && !rx_dma_req && !tx_dma_req));
   p_tx_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count == '0) |-> !eng_tx_valid);
endmodule

// File: tb/spi_fifo_stat_unit_test.sv
module spi_fifo_stat_unit_test;
   logic clk = 0, rst_n = 0;
   logic tx_fifo_off, rx_fifo_off, rx_overwrite, tx_flush, rx_flush;
   logic tx_push, eng_tx_req, eng_rx_valid, rx_pop, eng_eoq, eng_done, eng_busy;
   logic [15:0] tx_push_data, eng_tx_data;
   logic [31:0] eng_rx_data, rx_pop_data;
   logic eng_tx_valid, irq, rx_dma_req, tx_dma_req, rx_drain_dma, tx_fill_dma;
   logic [6:0] flag_clr, flags;
   logic [5:0] req_en;
   logic [3:0] tx_count, tx_ptr, rx_count, rx_ptr;
   int n_cmp = 0, n_bad = 0;

   always #5 clk = ~clk;

   spi_fifo_stat_unit uut (.*);

   task automatic step(); @(posedge clk); #1; endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      {tx_fifo_off, rx_fifo_off, rx_overwrite, tx_flush, rx_flush} = '0;
      {tx_push, eng_tx_req, eng_rx_valid, rx_pop, eng_eoq, eng_done, eng_busy} = '0;
      tx_push_data = '0; eng_rx_data = '0; flag_clr = '0; req_en = '0;
      rx_drain_dma = 0; tx_fill_dma = 0;
   endtask

   task automatic clr_all(); flag_clr = '1; step(); flag_clr = '0; endtask
   task automatic flush_both(); tx_flush = 1; rx_flush = 1; step(); tx_flush = 0; rx_flush = 0; endtask
   task automatic txw(input logic [15:0] d); tx_push = 1; tx_push_data = d; step(); tx_push = 0; endtask
   task automatic rxw(input logic [31:0] d); eng_rx_valid = 1; eng_rx_data = d; step(); eng_rx_valid = 0; endtask
   task automatic rxr(input string req, input logic [31:0] exp);
      rx_pop = 1; #1; chk(req, rx_pop_data, exp); step(); rx_pop = 0;
   endtask
   task automatic txr(input string req, input logic [15:0] exp);
      eng_tx_req = 1; #1; chk(req, {eng_tx_valid, eng_tx_data}, {1'b1, exp}); step(); eng_tx_req = 0;
   endtask

   task automatic t_reset();
      idle(); rst_n = 0; #1;
      chk("R1 flags", flags, 0);
      chk("R1 counts", {tx_count, tx_ptr, rx_count, rx_ptr}, 0);
      chk("R1 requests", {irq, rx_dma_req, tx_dma_req}, 0);
      step(); rst_n = 1; step();
      chk("R1 fill after reset", flags, 7'b0000100);
   endtask

   task automatic t_tx_order();
      flush_both();
      chk("R5 tx flushed", {tx_count, tx_ptr}, 0);
      for (int i = 0; i < 4; i++) txw(16'hA0 + 16'(i));
      chk("R2 tx count full", {tx_count, tx_ptr}, {4'd4, 4'd0});
      txw(16'hBEEF);
      chk("R2 push to full ignored", tx_count, 4);
      flag_clr = 7'b0000100; step(); flag_clr = '0;
      chk("R8 fill clears when full", flags[2], 0);
      for (int i = 0; i < 4; i++) begin
         txr("R2 tx order", 16'hA0 + 16'(i));
         chk("R2 tx ptr/count", {tx_ptr, tx_count}, {4'((i + 1) % 4), 4'(3 - i)});
      end
      step();
      chk("R8 fill set again", flags[2], 1);
   endtask

   task automatic t_underflow();
      clr_all();
      eng_tx_req = 1; #1;
      chk("R4 no valid when empty", eng_tx_valid, 0);
      step(); eng_tx_req = 0;
      chk("R4 underflow flag", flags[3], 1);
      req_en = 6'b001000; #1;
      chk("R9 enabled underflow irq", irq, 1);
      flag_clr = 7'b0001000; step(); flag_clr = '0;
      chk("R7 underflow cleared", {flags[3], irq}, 0);
      req_en = '0;
   endtask

   task automatic t_rx_drop();
      flush_both(); clr_all(); rx_overwrite = 0;
      for (int i = 0; i < 5; i++) rxw(32'hB0 + 32'(i));
      chk("R3 drop count", rx_count, 4);
      chk("R3 overflow flag", flags[1], 1);
      for (int i = 0; i < 4; i++) rxr("R3 drop keeps oldest", 32'hB0 + 32'(i));
      chk("R2 rx empty", {rx_count, rx_ptr}, 0);
   endtask

   task automatic t_rx_overwrite();
      flush_both(); clr_all(); rx_overwrite = 1;
      for (int i = 0; i < 5; i++) rxw(32'hC0 + 32'(i));
      chk("R3 overwrite count/ptr", {rx_count, rx_ptr}, {4'd4, 4'd1});
      chk("R3 overflow flag ovw", flags[1], 1);
      for (int i = 1; i < 5; i++) rxr("R3 overwrite order", 32'hC0 + 32'(i));
      rx_overwrite = 0;
   endtask

   task automatic t_flush_push();
      flush_both();
      txw(16'hD0); txw(16'hD1);
      tx_flush = 1; tx_push = 1; tx_push_data = 16'hD2; step(); tx_flush = 0; tx_push = 0;
      chk("R5 flush beats push", {tx_count, tx_ptr}, 0);
      txw(16'hE0);
      chk("R5 count after flush", tx_count, 1);
      txr("R5 first word after flush", 16'hE0);
   endtask

   task automatic t_single();
      flush_both(); clr_all();
      tx_fifo_off = 1;
      txw(16'hF0); txw(16'hF1);
      chk("R6 tx single cap", tx_count, 1);
      txr("R6 tx single data", 16'hF0);
      tx_fifo_off = 0;
      rx_fifo_off = 1; rx_overwrite = 0;
      rxw(32'h60); rxw(32'h61);
      chk("R6 rx single cap", rx_count, 1);
      chk("R6 rx single overflow", flags[1], 1);
      rxr("R6 rx single drop", 32'h60);
      rx_overwrite = 1;
      rxw(32'h70); rxw(32'h71);
      chk("R6 rx single ovw cap", rx_count, 1);
      rxr("R6 rx single overwrite", 32'h71);
      rx_fifo_off = 0; rx_overwrite = 0;
   endtask

   task automatic t_w1c();
      flush_both(); clr_all();
      eng_eoq = 1; step(); eng_eoq = 0;
      chk("R11 eoq flag", flags[4], 1);
      flag_clr = 7'b0100000; step(); flag_clr = '0;
      chk("R7 other bit clear no effect", flags[4], 1);
      flag_clr = 7'b0010000; eng_eoq = 1; step(); flag_clr = '0; eng_eoq = 0;
      chk("R7 set wins over clear", flags[4], 1);
      flag_clr = 7'b0010000; step(); flag_clr = '0;
      chk("R7 eoq cleared", flags[4], 0);
      eng_done = 1; step(); eng_done = 0;
      chk("R11 tc flag", flags[5], 1);
      eng_busy = 1; step();
      flag_clr = 7'b1000000; step(); flag_clr = '0;
      chk("R11 run held while busy", flags[6], 1);
      eng_busy = 0; flag_clr = 7'b1000000; step(); flag_clr = '0;
      chk("R11 run cleared", flags[6], 0);
   endtask

   task automatic t_requests();
      flush_both(); clr_all();
      rxw(32'h99); step();
      chk("R8 drain set", flags[0], 1);
      flag_clr = 7'b0000001; step(); flag_clr = '0;
      chk("R8 drain held", flags[0], 1);
      req_en = '0; #1;
      chk("R9 no enable no request", {irq, rx_dma_req, tx_dma_req}, 0);
      req_en = 6'b000001; rx_drain_dma = 0; #1;
      chk("R10 drain to irq", {irq, rx_dma_req}, 2'b10);
      rx_drain_dma = 1; #1;
      chk("R10 drain to dma", {irq, rx_dma_req}, 2'b01);
      req_en = 6'b000100; tx_fill_dma = 1; #1;
      chk("R10 fill to dma", {irq, tx_dma_req}, 2'b01);
      tx_fill_dma = 0; #1;
      chk("R10 fill to irq", {irq, tx_dma_req}, 2'b10);
      req_en = '0; rx_drain_dma = 0;
      rxr("R2 rx single word", 32'h99);
      step();
      flag_clr = 7'b0000001; step(); flag_clr = '0;
      chk("R8 drain clears when empty", flags[0], 0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      t_reset();
      t_tx_order();
      t_underflow();
      t_rx_drop();
      t_rx_overwrite();
      t_flush_push();
      t_single();
      t_w1c();
      t_requests();
      summary();
   end
endmodule